// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Controller

This block keeps the contents of an asynchronous DRAM alive. After reset it waits a fixed power-up pause. It then runs a burst of CAS-before-RAS refresh cycles to initialise the device. Once that burst is finished it raises `initDone`, which releases the access sequencer. From then on an interval counter asks for one refresh per period. The period is chosen so that every row is refreshed well inside the retention time; for example, about 15.6 µs covers 2048 rows in 32 ms. The device keeps its own row pointer, so the block drives only the two strobes and no address.

The block shares the strobe lines with the access sequencer through a request/grant handshake. It raises `refReq` while work is pending and moves the strobes only while `refGnt` is high. If the grant is withheld, the intervals that pass are stored as a refresh debt, up to a limit. The debt is paid back with back-to-back cycles as soon as the grant arrives. A `reinit` pulse re-runs the initialisation burst without the power-up pause. It is used after the clock has been stopped for longer than the device allows.

All timing is set by parameters in clock cycles:
- `PWRUP_CYCLES`: power-up pause.
- `INIT_CYCLES`: number of initialisation cycles.
- `REF_INTERVAL`: refresh period.
- `CSR_CYCLES`: how long CAS is low before RAS falls.
- `CHR_CYCLES`: how long CAS stays low after RAS falls.
- `RAS_CYCLES`: RAS low width.
- `RP_CYCLES`: RAS precharge.
- `DEBT_MAX`: largest stored debt.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While `rstN` is low, `rasN` and `casN` are 1, and `refReq` and `initDone` are 0.
- R2: `refReq` rises exactly `PWRUP_CYCLES` cycles after reset is released. No strobe falls before then.
- R3: After the pause, exactly `INIT_CYCLES` refresh cycles run. `initDone` stays 0 until the precharge of the last of them has ended, and it is 1 afterwards.
- R4: Each cycle is CAS-before-RAS. `casN` falls while `rasN` is 1, and `rasN` falls exactly `CSR_CYCLES` cycles later, with `casN` still 0.
- R5: `casN` stays 0 for exactly `CHR_CYCLES` cycles after `rasN` falls. It then rises while `rasN` is still 0.
- R6: `rasN` stays 0 for exactly `RAS_CYCLES` cycles. It stays 1 for at least `RP_CYCLES` cycles before it falls again.
- R7: `rasN` or `casN` is 0 only while `refGnt` and `refReq` are both 1. While the grant is withheld, both strobes stay 1.
- R8: After `initDone` rises, one refresh runs for each `REF_INTERVAL` cycles.
- R9: Intervals that pass without a grant are stored, up to `DEBT_MAX`; intervals beyond that are dropped. When the grant arrives, the stored cycles run back to back, with rising edges of `rasN` spaced `CSR_CYCLES+RAS_CYCLES+RP_CYCLES+1` cycles apart.
- R10: A one-cycle `reinit` pulse drops `initDone` in the next cycle. It then runs `INIT_CYCLES` cycles at once, without the power-up pause, and `initDone` rises again. Interval pacing restarts from zero after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reinit | input | 1 | One-cycle pulse that requests a new initialisation burst |
| refGnt | input | 1 | Grant of the strobe lines from the access sequencer |
| refReq | output | 1 | Request for the strobe lines |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| initDone | output | 1 | High once initialisation is complete |

## Verification
The properties assume that the access sequencer never takes `refGnt` away while `refReq` is high. They also assume that `reinit` arrives only while no refresh cycle is running. The bench arbiter follows both rules. It grants after a programmable delay and holds the grant until the request falls. It withholds the grant only while no cycle is in flight. The bench pulses `reinit` only after the last refresh has completed. The bench aligns its grant windows to known interval ticks, so the number of refreshes in each window is exact rather than approximate.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CSU,
    PH_HOLD,
    PH_RLOW,
    PH_PRE
  } phase_t;

  typedef struct packed {
    logic   loadTimer;
    phase_t loadPhase;
    logic   finish;
  } ctrl_strobe_t;

  typedef struct packed {
    logic pauseDone;
    logic workPending;
    logic timerLast;
  } dp_status_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import dram_refresh_pkg::*;
#(
  parameter int PWRUP_CYCLES = 20000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 1500,
  parameter int CSR_CYCLES   = 1,
  parameter int CHR_CYCLES   = 2,
  parameter int RAS_CYCLES   = 7,
  parameter int RP_CYCLES    = 5,
  parameter int DEBT_MAX     = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reinit,
  input  ctrl_strobe_t strobe,
  output dp_status_t   status,
  output logic         initDone
);

  localparam int PAUSE_W = $clog2(PWRUP_CYCLES + 1);
  localparam int IVL_W   = $clog2(REF_INTERVAL + 1);
  localparam int INIT_W  = $clog2(INIT_CYCLES + 1);
  localparam int DEBT_W  = $clog2(DEBT_MAX + 1);
  localparam int RLOW_CYCLES = RAS_CYCLES - CHR_CYCLES;
  localparam int MAX_AB  = (CSR_CYCLES > CHR_CYCLES) ? CSR_CYCLES : CHR_CYCLES;
  localparam int MAX_CD  = (RLOW_CYCLES > RP_CYCLES) ? RLOW_CYCLES : RP_CYCLES;
  localparam int MAX_PH  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W   = $clog2(MAX_PH + 1);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [IVL_W-1:0]   ivlCnt;
  logic [INIT_W-1:0]  initLeft;
  logic [DEBT_W-1:0]  debt;
  logic [TMR_W-1:0]   timer;
  logic [TMR_W-1:0]   phaseLen;
  logic               pauseDone;
  logic               ivlTick;
  logic               debtInc;
  logic               debtDec;

  assign pauseDone = (pauseCnt == '0);
  assign initDone  = pauseDone && (initLeft == '0);
  assign ivlTick   = initDone && (ivlCnt == IVL_W'(REF_INTERVAL - 1));
  assign debtInc   = ivlTick && (debt != DEBT_W'(DEBT_MAX));
  assign debtDec   = strobe.finish && (initLeft == '0) && (debt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) pauseCnt <= PAUSE_W'(PWRUP_CYCLES);
    else if (!pauseDone) pauseCnt <= pauseCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || reinit) initLeft <= INIT_W'(INIT_CYCLES);
    else if (strobe.finish && initLeft != '0) initLeft <= initLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !initDone) ivlCnt <= '0;
    else if (ivlTick) ivlCnt <= '0;
    else ivlCnt <= ivlCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) debt <= '0;
    else if (debtInc && !debtDec) debt <= debt + 1'b1;
    else if (debtDec && !debtInc) debt <= debt - 1'b1;
  end

  always_comb begin
    case (strobe.loadPhase)
      PH_CSU:  phaseLen = TMR_W'(CSR_CYCLES);
      PH_HOLD: phaseLen = TMR_W'(CHR_CYCLES);
      PH_RLOW: phaseLen = TMR_W'(RLOW_CYCLES);
      PH_PRE:  phaseLen = TMR_W'(RP_CYCLES);
      default: phaseLen = TMR_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else if (strobe.loadTimer) timer <= phaseLen;
    else if (timer != '0) timer <= timer - 1'b1;
  end

  assign status.pauseDone   = pauseDone;
  assign status.workPending = pauseDone && (initLeft != '0 || debt != '0);
  assign status.timerLast   = (timer == TMR_W'(1));

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import dram_refresh_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         refGnt,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         refReq,
  output logic         rasN,
  output logic         casN
);

  phase_t phase;
  phase_t nextPhase;
  logic   loadTimer;
  logic   finish;

  always_comb begin
    nextPhase = phase;
    loadTimer = 1'b0;
    finish    = 1'b0;
    case (phase)
      PH_IDLE: if (status.workPending && refGnt) begin
        nextPhase = PH_CSU;
        loadTimer = 1'b1;
      end
      PH_CSU: if (status.timerLast) begin
        nextPhase = PH_HOLD;
        loadTimer = 1'b1;
      end
      PH_HOLD: if (status.timerLast) begin
        nextPhase = PH_RLOW;
        loadTimer = 1'b1;
      end
      PH_RLOW: if (status.timerLast) begin
        nextPhase = PH_PRE;
        loadTimer = 1'b1;
      end
      PH_PRE: if (status.timerLast) begin
        nextPhase = PH_IDLE;
        finish    = 1'b1;
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  assign strobe.loadTimer = loadTimer;
  assign strobe.loadPhase = nextPhase;
  assign strobe.finish    = finish;
  assign refReq = (phase == PH_IDLE) ? status.workPending : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      rasN  <= 1'b1;
      casN  <= 1'b1;
    end else begin
      phase <= nextPhase;
      rasN  <= !(nextPhase == PH_HOLD || nextPhase == PH_RLOW);
      casN  <= !(nextPhase == PH_CSU || nextPhase == PH_HOLD);
    end
  end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_refresh_pkg::*;
#(
  parameter int PWRUP_CYCLES = 20000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 1500,
  parameter int CSR_CYCLES   = 1,
  parameter int CHR_CYCLES   = 2,
  parameter int RAS_CYCLES   = 7,
  parameter int RP_CYCLES    = 5,
  parameter int DEBT_MAX     = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic reinit,
  input  logic refGnt,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic initDone
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  refresh_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .refGnt (refGnt),
    .status (status),
    .strobe (strobe),
    .refReq (refReq),
    .rasN   (rasN),
    .casN   (casN)
  );

  refresh_datapath #(
    .PWRUP_CYCLES (PWRUP_CYCLES),
    .INIT_CYCLES  (INIT_CYCLES),
    .REF_INTERVAL (REF_INTERVAL),
    .CSR_CYCLES   (CSR_CYCLES),
    .CHR_CYCLES   (CHR_CYCLES),
    .RAS_CYCLES   (RAS_CYCLES),
    .RP_CYCLES    (RP_CYCLES),
    .DEBT_MAX     (DEBT_MAX)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .reinit   (reinit),
    .strobe   (strobe),
    .status   (status),
    .initDone (initDone)
  );

endmodule

// File: rtl/refresh_checker.sv
module refresh_checker #(
  parameter int PWRUP_CYCLES = 20000,
  parameter int RAS_CYCLES   = 7
) (
  input logic clk,
  input logic rstN,
  input logic reinit,
  input logic refGnt,
  input logic refReq,
  input logic rasN,
  input logic casN,
  input logic initDone
);

  localparam int SINCE_W = $clog2(PWRUP_CYCLES + 1);
  localparam int LOW_W   = $clog2(RAS_CYCLES + 2);

  logic [SINCE_W-1:0] sinceRst;
  logic [LOW_W-1:0]   lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != SINCE_W'(PWRUP_CYCLES)) sinceRst <= sinceRst + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || rasN) lowCnt <= '0;
    else if (lowCnt != '1) lowCnt <= lowCnt + 1'b1;
  end

  p_no_req_in_pause_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < SINCE_W'(PWRUP_CYCLES)) |-> (!refReq && rasN && casN));

  p_cas_falls_ras_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> rasN);

  p_ras_falls_cas_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  p_cas_rises_ras_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casN) |-> !rasN);

  p_ras_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowCnt == LOW_W'(RAS_CYCLES)));

  p_strobe_needs_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> (refGnt && refReq));

  p_reinit_clears_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    reinit |=> !initDone);

endmodule

bind dram_refresh_ctrl refresh_checker #(
  .PWRUP_CYCLES (PWRUP_CYCLES),
  .RAS_CYCLES   (RAS_CYCLES)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reinit   (reinit),
  .refGnt   (refGnt),
  .refReq   (refReq),
  .rasN     (rasN),
  .casN     (casN),
  .initDone (initDone)
);

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int PW    = 50;
  localparam int NINIT = 8;
  localparam int IVL   = 80;
  localparam int CSR_C = 2;
  localparam int CHR_C = 2;
  localparam int RAS_C = 6;
  localparam int RP_C  = 4;
  localparam int DMAX  = 3;
  localparam int BURST = CSR_C + RAS_C + RP_C + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reinit = 1'b0;
  logic refGnt = 1'b0;
  logic refReq, rasN, casN, initDone;

  dram_refresh_ctrl #(
    .PWRUP_CYCLES (PW),
    .INIT_CYCLES  (NINIT),
    .REF_INTERVAL (IVL),
    .CSR_CYCLES   (CSR_C),
    .CHR_CYCLES   (CHR_C),
    .RAS_CYCLES   (RAS_C),
    .RP_CYCLES    (RP_C),
    .DEBT_MAX     (DMAX)
  ) uut (
    .clk      (clk),
    .rstN     (rstN),
    .reinit   (reinit),
    .refGnt   (refGnt),
    .refReq   (refReq),
    .rasN     (rasN),
    .casN     (casN),
    .initDone (initDone)
  );

  typedef struct {
    int csr;
    int chr;
    int rasw;
  } shape_t;

  shape_t sb[$];
  int     fallTimes[$];
  int     checks = 0;
  int     fails = 0;
  int     falls = 0;
  int     rises = 0;
  bit     finished = 0;
  bit     blockGnt = 0;
  int     gntDelay = 0;

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expectRefreshes(int n);
    for (int i = 0; i < n; i++) sb.push_back('{CSR_C, CHR_C, RAS_C});
  endtask

  task automatic finishTest();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Arbiter: grants after gntDelay cycles, holds grant while request is high
  initial begin
    int waitCnt = 0;
    forever begin
      @(posedge clk);
      #2;
      if (!refReq) begin
        refGnt = 1'b0;
        waitCnt = 0;
      end else if (!refGnt) begin
        if (blockGnt) waitCnt = 0;
        else if (waitCnt >= gntDelay) refGnt = 1'b1;
        else waitCnt++;
      end
    end
  end

  // Monitor: measures strobe edges and compares against expected shapes
  initial begin
    int cyc = 0;
    int casFallT = 0;
    int rasFallT = 0;
    int casRiseT = 0;
    int lastRise = -1;
    logic pRas = 1'b1;
    logic pCas = 1'b1;
    shape_t item;
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        if (pCas && !casN) begin
          casFallT = cyc;
          check(rasN === 1'b1, "R4 ras high at cas fall", int'(rasN), 1);
        end
        if (pRas && !rasN) begin
          rasFallT = cyc;
          falls++;
          fallTimes.push_back(cyc);
          check(refGnt === 1'b1, "R7 grant at ras fall", int'(refGnt), 1);
          check(casN === 1'b0, "R4 cas low at ras fall", int'(casN), 0);
          if (lastRise >= 0)
            check(cyc - lastRise >= RP_C, "R6 precharge", cyc - lastRise, RP_C);
        end
        if (!pCas && casN) begin
          casRiseT = cyc;
          check(rasN === 1'b0, "R5 ras low at cas rise", int'(rasN), 0);
        end
        if (!pRas && rasN) begin
          lastRise = cyc;
          rises++;
          if (sb.size() == 0) begin
            check(1'b0, "R8 unexpected refresh", 1, 0);
          end else begin
            item = sb.pop_front();
            check(rasFallT - casFallT == item.csr, "R4 cas setup", rasFallT - casFallT, item.csr);
            check(casRiseT - rasFallT == item.chr, "R5 cas hold", casRiseT - rasFallT, item.chr);
            check(cyc - rasFallT == item.rasw, "R6 ras width", cyc - rasFallT, item.rasw);
          end
        end
      end
      pRas = rasN;
      pCas = casN;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all R): actual %0d expected %0d", 1, 0);
      finishTest();
    end
  end

  initial begin
    int n;
    int base;
    int ftIdx;
    bit anyLow;
    repeat (3) tick();
    check(rasN === 1'b1 && casN === 1'b1 && refReq === 1'b0 && initDone === 1'b0,
          "R1 reset state", int'({rasN, casN, refReq, initDone}), 12);
    rstN = 1'b1;

    n = 0;
    while (!refReq && n < 1000) begin
      tick();
      n++;
    end
    check(n == PW, "R2 pause length", n, PW);
    check(falls == 0, "R2 no strobe during pause", falls, 0);
    check(initDone === 1'b0, "R2 not done after pause", int'(initDone), 0);

    expectRefreshes(NINIT);
    base = falls;
    while (!initDone) tick();
    check(falls - base == NINIT, "R3 init cycle count", falls - base, NINIT);
    check(rises == NINIT, "R3 done after last cycle", rises, NINIT);

    gntDelay = 3;
    expectRefreshes(10);
    base = falls;
    repeat (10 * IVL + IVL / 2) tick();
    check(falls - base == 10, "R8 refreshes per window", falls - base, 10);
    check(sb.size() == 0, "R8 expected refreshes seen", sb.size(), 0);

    blockGnt = 1;
    gntDelay = 0;
    base = falls;
    anyLow = 0;
    repeat (5 * IVL) begin
      tick();
      if (!rasN || !casN) anyLow = 1;
    end
    check(!anyLow, "R7 strobes idle without grant", int'(anyLow), 0);
    check(falls == base, "R7 no cycle without grant", falls - base, 0);
    check(refReq === 1'b1, "R9 request pending with debt", int'(refReq), 1);
    repeat (IVL / 2 + 5) tick();

    expectRefreshes(DMAX);
    base = falls;
    ftIdx = fallTimes.size();
    blockGnt = 0;
    repeat (IVL - 10) tick();
    check(falls - base == DMAX, "R9 saturated debt burst", falls - base, DMAX);
    if (falls - base >= DMAX) begin
      for (int i = 1; i < DMAX; i++)
        check(fallTimes[ftIdx + i] - fallTimes[ftIdx + i - 1] == BURST, "R9 back to back spacing",
              fallTimes[ftIdx + i] - fallTimes[ftIdx + i - 1], BURST);
    end

    expectRefreshes(1);
    repeat (IVL / 2) tick();

    reinit = 1'b1;
    tick();
    reinit = 1'b0;
    check(initDone === 1'b0, "R10 done drops", int'(initDone), 0);
    expectRefreshes(NINIT);
    base = falls;
    n = 0;
    while (falls == base && n < 1000) begin
      tick();
      n++;
    end
    check(n <= CSR_C + 3, "R10 no pause before reinit cycles", n, CSR_C + 3);
    while (!initDone) tick();
    check(falls - base == NINIT, "R10 reinit cycle count", falls - base, NINIT);

    expectRefreshes(2);
    base = falls;
    repeat (2 * IVL + IVL / 2) tick();
    check(falls - base == 2, "R10 interval restart", falls - base, 2);
    check(sb.size() == 0, "R8 all expected refreshes seen", sb.size(), 0);

    finishTest();
  end

endmodule